// File: doc/BRIEF.md
# Reload and One-Shot Interval Timer

An 8-bit down-counting interval timer. Software writes a period value into a reload buffer and sets the enable bit. The counter then loads that value and counts down by one on each cycle where the chosen prescaled tick is high. A 2-bit field picks that tick from a small set of tick inputs. The step from 01h to 00h is the underflow event. Each underflow inverts a timer output level. One selected tick later, it raises a sticky underflow flag, which drives an interrupt request when the interrupt enable is set.

A mode bit picks between two behaviours. In continuous reload mode the counter refills from the buffer on every underflow and keeps running. In one-shot mode the underflow clears the enable bit, so the counter halts at 00h. If software changes the buffer while a period is in progress, the period already under way keeps its old length, and the new value is used from the next load.

Registers are written through a simple write strobe with a 2-bit address. They are read back through a combinational read port.

Top module: `itimer_top`

## Requirements
- R1: After reset, the control, config, reload and count registers all read 00h, and `irq` and `tmr_out` are 0. Register addresses are: control = 0, config = 1, reload buffer = 2, count = 3 (read-only). Control bits are: bit0 enable, bit1 interrupt enable, bit2 underflow flag, bit3 one-shot mode (0 = reload mode). Config bits are: bits[1:0] tick select, bit2 output level.
- R2: A control write that sets enable while the timer is stopped loads the counter from the reload buffer on that write's clock edge. A control write that clears enable stops counting, and the count holds its value.
- R3: The running counter decrements only on cycles where `tick_in[sel]` is 1, where sel is config bits[1:0]. Pulses on the other tick inputs have no effect.
- R4: In one-shot mode, the tick that takes the count from 01h to 00h also clears enable. The count then stays at 00h under further ticks.
- R5: Every underflow inverts `tmr_out`. A config write sets `tmr_out` to config bit2 on its edge, and this write takes precedence over a toggle in the same cycle.
- R6: The underflow flag is still 0 right after the underflow edge. It becomes 1 on the next cycle with the selected tick high.
- R7: Once set, the underflow flag stays set. A control write with bit2 = 0 clears it, and a write with bit2 = 1 leaves it unchanged.
- R8: `irq` is 1 exactly when the underflow flag and the interrupt enable are both 1.
- R9: In reload mode, an underflow reloads the counter from the buffer and leaves enable set. A buffer write made mid-period does not shorten or lengthen the current period; it is used from the next reload.
- R10: In reload mode with a reload value of 01h, `tmr_out` inverts on every selected tick.
- R11: A reload value of 00h gives a period of 256 selected ticks. The first tick after the load takes the count to FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 4 | Prescaled tick enables, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| tmr_out | output | 1 | Timer output level |

## Verification
The assertions on counter hold, reload and toggle assume that a selected tick does not arrive in the same cycle as a control write. When both happen together, the write takes priority, and the properties exclude that case in their antecedents. The stimulus drives ticks and register writes in separate cycles, always one strobe per task call. This makes every expected value follow from a single event. The tick select is only changed while the counter is stopped.

// File: rtl/itimer_pkg.sv
// Shared register addresses and bit positions for the interval timer.
// Assumes the data path is at least 4 bits wide.
package itimer_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_CFG    = 2'd1;
    localparam logic [ADDR_W-1:0] A_RELOAD = 2'd2;
    localparam logic [ADDR_W-1:0] A_COUNT  = 2'd3;

    localparam int B_RUN     = 0;
    localparam int B_IE      = 1;
    localparam int B_UF      = 2;
    localparam int B_ONESHOT = 3;
endpackage

// File: rtl/itimer_tick_sel.sv
// Picks one count-enable tick out of NUM_TICKS sources.
// Assumes NUM_TICKS >= 2. A select value beyond the last source yields no tick.
module itimer_tick_sel #(
    parameter int NUM_TICKS = 4,
    parameter int SEL_W     = $clog2(NUM_TICKS)
) (
    input  logic [NUM_TICKS-1:0] tick_i,
    input  logic [SEL_W-1:0]     sel_i,
    output logic                 tick_o
);
    logic [NUM_TICKS-1:0] hit;

    // One decode line per source, built by generate.
    for (genvar g = 0; g < NUM_TICKS; g++) begin : g_src
        assign hit[g] = (sel_i == SEL_W'(g)) && tick_i[g];
    end

    // Reduce the decoded lines to one enable.
    always_comb begin
        tick_o = |hit;
    end
endmodule

// File: rtl/itimer_regs.sv
// Register decode for the timer: holds the reload buffer, mode,
// interrupt enable and tick select. Forwards control and config write
// strobes to the core and builds the combinational read data.
// Assumes a single write port with no wait states.
module itimer_regs
    import itimer_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              run_i,
    input  logic              uf_i,
    input  logic              out_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [CNT_W-1:0]  rd_data,
    output logic [CNT_W-1:0]  reload_buf,
    output logic              ie,
    output logic              oneshot,
    output logic [SEL_W-1:0]  clk_sel,
    output logic              ctrl_wr,
    output logic              run_wdat,
    output logic              uf_wdat,
    output logic              cfg_wr,
    output logic              out_wdat
);
    logic reload_wr;

    // Decode the write strobes.
    always_comb begin
        ctrl_wr   = wr_en && (wr_addr == A_CTRL);
        cfg_wr    = wr_en && (wr_addr == A_CFG);
        reload_wr = wr_en && (wr_addr == A_RELOAD);
        run_wdat  = wr_data[B_RUN];
        uf_wdat   = wr_data[B_UF];
        out_wdat  = wr_data[SEL_W];
    end

    // Hold the software-owned configuration bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_buf <= '0;
            ie         <= 1'b0;
            oneshot    <= 1'b0;
            clk_sel    <= '0;
        end else begin
            if (reload_wr) reload_buf <= wr_data;
            if (ctrl_wr) begin
                ie      <= wr_data[B_IE];
                oneshot <= wr_data[B_ONESHOT];
            end
            if (cfg_wr) clk_sel <= wr_data[SEL_W-1:0];
        end
    end

    // Assemble the read data for the addressed register.
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL: begin
                rd_data[B_RUN]     = run_i;
                rd_data[B_IE]      = ie;
                rd_data[B_UF]      = uf_i;
                rd_data[B_ONESHOT] = oneshot;
            end
            A_CFG: begin
                rd_data[SEL_W-1:0] = clk_sel;
                rd_data[SEL_W]     = out_i;
            end
            A_RELOAD: rd_data = reload_buf;
            A_COUNT:  rd_data = cnt_i;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/itimer_core.sv
// Counting engine: load on start, decrement on the selected tick,
// underflow on the 1 -> 0 step, output toggle, delayed sticky flag,
// and one-shot self-stop.
// Assumes the tick is a one-cycle enable. On a clash, a control write
// takes priority over counting.
module itimer_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             oneshot,
    input  logic [CNT_W-1:0] reload_buf,
    input  logic             ctrl_wr,
    input  logic             run_wdat,
    input  logic             uf_wdat,
    input  logic             cfg_wr,
    input  logic             out_wdat,
    output logic             run_o,
    output logic             uf_o,
    output logic             out_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic start, stop_req, step, uf_evt, pend;

    // Classify this cycle's events.
    always_comb begin
        start    = ctrl_wr && run_wdat && !run_o;
        stop_req = ctrl_wr && !run_wdat;
        step     = run_o && tick && !stop_req;
        uf_evt   = step && (cnt_o == ONE);
    end

    // Enable bit: set by software, cleared by software or a one-shot underflow.
    always_ff @(posedge clk) begin
        if (!rst_n)                  run_o <= 1'b0;
        else if (start)              run_o <= 1'b1;
        else if (stop_req)           run_o <= 1'b0;
        else if (uf_evt && oneshot)  run_o <= 1'b0;
    end

    // Counter: load, reload or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_o <= '0;
        else if (start)   cnt_o <= reload_buf;
        else if (uf_evt)  cnt_o <= oneshot ? '0 : reload_buf;
        else if (step)    cnt_o <= cnt_o - ONE;
    end

    // Timer output level: software write first, then underflow toggle.
    always_ff @(posedge clk) begin
        if (!rst_n)       out_o <= 1'b0;
        else if (cfg_wr)  out_o <= out_wdat;
        else if (uf_evt)  out_o <= ~out_o;
    end

    // Pending marker: the flag is posted on the next selected tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend <= 1'b0;
        else if (uf_evt)  pend <= 1'b1;
        else if (tick)    pend <= 1'b0;
    end

    // Sticky underflow flag: posting wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                   uf_o <= 1'b0;
        else if (tick && pend)        uf_o <= 1'b1;
        else if (ctrl_wr && !uf_wdat) uf_o <= 1'b0;
    end

    a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && run_wdat && !run_o) |=> (cnt_o == $past(reload_buf)));

    a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ctrl_wr) |=> $stable(cnt_o));

    a_r4_oneshot_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && tick && oneshot && cnt_o == ONE && !ctrl_wr) |=> (!run_o && cnt_o == '0));

    a_r5_out_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && tick && cnt_o == ONE && !ctrl_wr && !cfg_wr) |=> (out_o != $past(out_o)));

    a_r6_flag_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uf_o) |-> $past(tick));

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_o && !(ctrl_wr && !uf_wdat)) |=> uf_o);

    a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && tick && !oneshot && cnt_o == ONE && !ctrl_wr)
            |=> (run_o && cnt_o == $past(reload_buf)));
endmodule

// File: rtl/itimer_top.sv
// Interval timer top: tick select, register decode and counting core.
// Drives the interrupt request from the sticky flag and the interrupt enable.
// Assumes a synchronous active-low reset and single-cycle register writes.
module itimer_top #(
    parameter int CNT_W     = 8,
    parameter int NUM_TICKS = 4,
    localparam int SEL_W    = $clog2(NUM_TICKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TICKS-1:0] tick_in,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [CNT_W-1:0]     wr_data,
    input  logic [1:0]           rd_addr,
    output logic [CNT_W-1:0]     rd_data,
    output logic                 irq,
    output logic                 tmr_out
);
    logic             tick_sel, ie, oneshot;
    logic [SEL_W-1:0] clk_sel;
    logic [CNT_W-1:0] reload_buf, cnt;
    logic             ctrl_wr, run_wdat, uf_wdat, cfg_wr, out_wdat;
    logic             run, uf;

    itimer_tick_sel #(.NUM_TICKS(NUM_TICKS), .SEL_W(SEL_W)) u_sel (
        .tick_i(tick_in), .sel_i(clk_sel), .tick_o(tick_sel)
    );

    itimer_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .run_i(run), .uf_i(uf),
        .out_i(tmr_out), .cnt_i(cnt), .rd_data(rd_data),
        .reload_buf(reload_buf), .ie(ie), .oneshot(oneshot),
        .clk_sel(clk_sel), .ctrl_wr(ctrl_wr), .run_wdat(run_wdat),
        .uf_wdat(uf_wdat), .cfg_wr(cfg_wr), .out_wdat(out_wdat)
    );

    itimer_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick_sel), .oneshot(oneshot),
        .reload_buf(reload_buf), .ctrl_wr(ctrl_wr), .run_wdat(run_wdat),
        .uf_wdat(uf_wdat), .cfg_wr(cfg_wr), .out_wdat(out_wdat),
        .run_o(run), .uf_o(uf), .out_o(tmr_out), .cnt_o(cnt)
    );

    // Interrupt request: flag qualified by its enable.
    always_comb begin
        irq = uf && ie;
    end

    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (ie && uf));
endmodule

// File: tb/itimer_top_tb_top.sv
`timescale 1ns/1ps
module itimer_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tick_in = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq, tmr_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    itimer_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq), .tmr_out(tmr_out)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tk(input logic [3:0] m);
        @(negedge clk);
        tick_in = m;
        @(negedge clk);
        tick_in = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v); chk("R1 reg after reset", v, 8'h00);
        end
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);
        chk("R1 tmr_out after reset", {7'd0, tmr_out}, 8'h00);
    endtask

    task automatic t_select;
        logic [7:0] v;
        wr(2'd1, 8'h03);            // tick select 3, level 0
        wr(2'd2, 8'h09);
        wr(2'd0, 8'h01);            // start, reload mode
        rd(2'd3, v); chk("R2 load on start", v, 8'h09);
        tk(4'b0111);
        rd(2'd3, v); chk("R3 other ticks ignored", v, 8'h09);
        tk(4'b1000);
        rd(2'd3, v); chk("R3 selected tick counts", v, 8'h08);
        wr(2'd0, 8'h00);            // stop
        tk(4'b1000);
        rd(2'd3, v); chk("R2 stop holds count", v, 8'h08);
        rd(2'd0, v); chk("R2 enable cleared", v, 8'h00);
        wr(2'd1, 8'h04);            // select 0, level 1
        chk("R5 level written", {7'd0, tmr_out}, 8'h01);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_oneshot;
        logic [7:0] v;
        wr(2'd2, 8'h03);
        wr(2'd0, 8'h09);            // one-shot, start
        tk(4'b0001); tk(4'b0001);
        rd(2'd3, v); chk("R2 count after two ticks", v, 8'h01);
        tk(4'b0001);
        rd(2'd3, v); chk("R4 count at zero", v, 8'h00);
        rd(2'd0, v); chk("R4 enable self-cleared, R6 flag not yet", v, 8'h08);
        chk("R5 toggle on underflow", {7'd0, tmr_out}, 8'h01);
        tk(4'b0001);
        rd(2'd0, v); chk("R6 flag on next tick", v, 8'h0C);
        rd(2'd3, v); chk("R4 count stays zero", v, 8'h00);
        chk("R8 irq off without enable", {7'd0, irq}, 8'h00);
        wr(2'd0, 8'h0E);            // ie on, keep flag
        chk("R8 irq with enable", {7'd0, irq}, 8'h01);
        rd(2'd0, v); chk("R7 write 1 keeps flag", v, 8'h0E);
        tk(4'b0001);
        rd(2'd0, v); chk("R7 flag sticky", v, 8'h0E);
        wr(2'd0, 8'h0A);            // clear flag
        rd(2'd0, v); chk("R7 write 0 clears flag", v, 8'h0A);
        chk("R8 irq drops", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_reload;
        logic [7:0] v;
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h02);
        wr(2'd0, 8'h01);            // reload mode, start
        tk(4'b0001); tk(4'b0001);
        rd(2'd3, v); chk("R9 reload after underflow", v, 8'h02);
        rd(2'd0, v); chk("R9 enable stays", v[0], 1'b1);
        chk("R5 toggle reload mode", {7'd0, tmr_out}, 8'h01);
        wr(2'd2, 8'h04);            // mid-period change
        tk(4'b0001);
        rd(2'd3, v); chk("R9 current period unchanged", v, 8'h01);
        tk(4'b0001);
        rd(2'd3, v); chk("R9 new value next period", v, 8'h04);
        chk("R5 second toggle", {7'd0, tmr_out}, 8'h00);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_fast;
        logic [7:0] v;
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h01);
        tk(4'b0001);
        chk("R10 toggle 1", {7'd0, tmr_out}, 8'h01);
        tk(4'b0001);
        chk("R10 toggle 2", {7'd0, tmr_out}, 8'h00);
        rd(2'd0, v); chk("R6 flag after reload-1 tick", v[2], 1'b1);
        tk(4'b0001);
        chk("R10 toggle 3", {7'd0, tmr_out}, 8'h01);
        rd(2'd3, v); chk("R10 count reloaded to 1", v, 8'h01);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_full;
        logic [7:0] v;
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h01);
        rd(2'd3, v); chk("R11 load zero", v, 8'h00);
        tk(4'b0001);
        rd(2'd3, v); chk("R11 wraps to FF", v, 8'hFF);
        for (int i = 0; i < 254; i++) tk(4'b0001);
        rd(2'd3, v); chk("R11 count 1 after 255 ticks", v, 8'h01);
        chk("R11 no early toggle", {7'd0, tmr_out}, 8'h00);
        tk(4'b0001);
        chk("R11 toggle on 256th tick", {7'd0, tmr_out}, 8'h01);
        wr(2'd0, 8'h00);
    endtask

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_select();
        t_oneshot();
        t_reload();
        t_fast();
        t_full();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule